// File: doc/BRIEF.md
# Key-Gated Indexed Configuration Port

This block sits on a simple byte-wide I/O bus and occupies two consecutive addresses. A write to the low address (offset 0) loads a register index. A read or write at the high address (offset 1) reaches whatever register that index points at. The port starts locked. Software opens it by writing an unlock byte to the index address a set number of times in a row, two by default. A different byte written to the index address closes it again.

Behind the port sit a few global registers. One selects the logical device. The others are read-only and report the chip identity, revision and maker code. Indices at or above a routing threshold are not held here. Accesses to them are forwarded to the logical device that the select register names. The forward is a request strobe, a write flag, the index, the write byte and a one-hot device select, all valid in the same cycle as the bus access. Read data comes back combinationally from the selected device. Logical device 6 is the GPIO register space, and its register file lies outside this block.

Top module: `cfg_port`

## Requirements
- R1: After reset the port is locked, the register index is 0x00 and the logical-device select is 0.
- R2: The port opens only after 0x87 has been written to offset 0 on two consecutive bus writes. Any other bus write in between, whether a different byte at offset 0 or any write at offset 1, restarts the count.
- R3: While open, writing 0xAA to offset 0 locks the port and leaves the index unchanged. Reopening the port gives back the previous index.
- R4: While locked, reads at either offset return 0xFF, writes at offset 1 change nothing, index writes other than the unlock byte are ignored, and no device request is raised.
- R5: While open, a write of any byte other than 0xAA to offset 0 loads the index, and a read at offset 0 returns the index.
- R6: Index 0x07 is the logical-device select: an 8-bit register written and read through offset 1.
- R7: Offset-1 reads return the chip ID high and low bytes at indices 0x20 and 0x21, the revision at 0x22, and the maker code 0x1934 at 0x23 (0x19) and 0x24 (0x34). Writes to these indices are ignored.
- R8: While open, an access at offset 1 with index 0x30 or above raises dev_req in the same cycle. dev_we equals the write strobe, dev_idx is the index, dev_wdata is the bus byte, and dev_sel has exactly bit N set, where N is the logical-device select (bit 6 is the GPIO space). A read returns byte lane N of dev_rdata (bits 8N+7..8N).
- R9: If the logical-device select is not below NUM_LD, dev_sel stays all zero and device reads return 0x00. Indices below 0x30 that are not listed above read 0x00 and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus cycle targets this port |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| dev_req | output | 1 | Forwarded device register access |
| dev_we | output | 1 | Forwarded access is a write |
| dev_sel | output | NUM_LD | One-hot logical device target |
| dev_idx | output | 8 | Forwarded register index |
| dev_wdata | output | 8 | Forwarded write byte |
| dev_rdata | input | 8*NUM_LD | Read bytes from every logical device, lane N for device N |

## Verification
The hardest case to reach is an unlock sequence that was almost finished and then broken. The port must stay locked both when a foreign index byte and when a data-port write falls between the two key bytes. Its only visible sign is that reads keep returning 0xFF. The stimulus therefore sends each broken sequence and then makes a read, which must still return 0xFF. Only after that does it send the clean pair. The lock path gets the matching treatment. A data write and an index write are issued while the port is locked. The port is then reopened, and the select register and the index are read back to show that neither was disturbed.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   // Global register indices; software decodes these positions.
   localparam logic [7:0] IDX_LDSEL    = 8'h07;
   localparam logic [7:0] IDX_CHIP_HI  = 8'h20;
   localparam logic [7:0] IDX_CHIP_LO  = 8'h21;
   localparam logic [7:0] IDX_REV      = 8'h22;
   localparam logic [7:0] IDX_MAKER_HI = 8'h23;
   localparam logic [7:0] IDX_MAKER_LO = 8'h24;
   localparam logic [7:0] BYTE_ONES    = 8'hFF;

   typedef enum logic {
      PORT_LOCKED = 1'b0,
      PORT_OPEN   = 1'b1
   } port_mode_e;
endpackage

// File: rtl/cfgport_keyseq.sv
module cfgport_keyseq
   import cfgport_pkg::*;
#(
   parameter int         KEY_WRITES = 2,
   parameter logic [7:0] UNLOCK_KEY = 8'h87,
   parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       any_wr,
   input  logic [7:0] wdata,
   output port_mode_e mode
);
   generate
      if (KEY_WRITES < 1 || KEY_WRITES > 255) begin : g_bad_count
         $error("KEY_WRITES must lie in 1..255");
      end

      if (KEY_WRITES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mode <= PORT_LOCKED;
            end else if (mode == PORT_LOCKED) begin
               if (any_wr && idx_wr && wdata == UNLOCK_KEY) mode <= PORT_OPEN;
            end else if (idx_wr && wdata == LOCK_KEY) begin
               mode <= PORT_LOCKED;
            end
         end
      end else begin : g_multi
         localparam int CNT_W = $clog2(KEY_WRITES);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_WRITES - 1);
         logic [CNT_W-1:0] seen_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mode   <= PORT_LOCKED;
               seen_q <= '0;
            end else if (mode == PORT_LOCKED) begin
               if (any_wr) begin
                  if (idx_wr && wdata == UNLOCK_KEY) begin
                     if (seen_q == LAST) begin
                        mode   <= PORT_OPEN;
                        seen_q <= '0;
                     end else begin
                        seen_q <= seen_q + 1'b1;
                     end
                  end else begin
                     seen_q <= '0;
                  end
               end
            end else if (idx_wr && wdata == LOCK_KEY) begin
               mode   <= PORT_LOCKED;
               seen_q <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cfgport_globals.sv
module cfgport_globals
   import cfgport_pkg::*;
#(
   parameter logic [15:0] CHIP_ID  = 16'h0A5C,
   parameter logic [7:0]  CHIP_REV = 8'h12,
   parameter logic [15:0] MAKER_ID = 16'h1934
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_load,
   input  logic       ldn_load,
   input  logic [7:0] wdata,
   output logic [7:0] index_q,
   output logic [7:0] ldn_q,
   output logic [7:0] glob_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= '0;
         ldn_q   <= '0;
      end else begin
         if (idx_load) index_q <= wdata;
         if (ldn_load) ldn_q   <= wdata;
      end
   end

   always_comb begin
      unique case (index_q)
         IDX_LDSEL:    glob_rdata = ldn_q;
         IDX_CHIP_HI:  glob_rdata = CHIP_ID[15:8];
         IDX_CHIP_LO:  glob_rdata = CHIP_ID[7:0];
         IDX_REV:      glob_rdata = CHIP_REV;
         IDX_MAKER_HI: glob_rdata = MAKER_ID[15:8];
         IDX_MAKER_LO: glob_rdata = MAKER_ID[7:0];
         default:      glob_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/cfgport_route.sv
module cfgport_route #(
   parameter int NUM_LD = 8
) (
   input  logic                  req,
   input  logic [7:0]            ldn,
   input  logic [NUM_LD*8-1:0]   dev_rdata,
   output logic [NUM_LD-1:0]     dev_sel,
   output logic [7:0]            sel_rdata
);
   generate
      if (NUM_LD < 1 || NUM_LD > 256) begin : g_bad_num
         $error("NUM_LD must lie in 1..256");
      end
      for (genvar k = 0; k < NUM_LD; k++) begin : g_sel
         assign dev_sel[k] = req && (ldn == 8'(k));
      end
   endgenerate

   always_comb begin
      sel_rdata = 8'h00;
      for (int k = 0; k < NUM_LD; k++) begin
         if (dev_sel[k]) sel_rdata = sel_rdata | dev_rdata[k*8 +: 8];
      end
   end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
   import cfgport_pkg::*;
#(
   parameter int          NUM_LD       = 8,
   parameter int          KEY_WRITES   = 2,
   parameter logic [7:0]  UNLOCK_KEY   = 8'h87,
   parameter logic [7:0]  LOCK_KEY     = 8'hAA,
   parameter logic [7:0]  DEV_BASE_IDX = 8'h30,
   parameter logic [15:0] CHIP_ID      = 16'h0A5C,
   parameter logic [7:0]  CHIP_REV     = 8'h12,
   parameter logic [15:0] MAKER_ID     = 16'h1934
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [7:0]          bus_wdata,
   output logic [7:0]          bus_rdata,
   output logic                dev_req,
   output logic                dev_we,
   output logic [NUM_LD-1:0]   dev_sel,
   output logic [7:0]          dev_idx,
   output logic [7:0]          dev_wdata,
   input  logic [NUM_LD*8-1:0] dev_rdata
);
   generate
      if (UNLOCK_KEY == LOCK_KEY) begin : g_bad_keys
         $error("UNLOCK_KEY and LOCK_KEY must differ");
      end
      if (DEV_BASE_IDX <= IDX_MAKER_LO) begin : g_bad_base
         $error("DEV_BASE_IDX must lie above the global registers");
      end
   endgenerate

   port_mode_e mode;
   logic       port_open;
   logic [7:0] index_q;
   logic [7:0] ldn_q;
   logic [7:0] glob_rdata;
   logic [7:0] sel_rdata;
   logic       any_wr, idx_wr, data_wr, data_acc, dev_range;

   assign any_wr    = bus_sel && bus_wr;
   assign idx_wr    = any_wr && !bus_addr;
   assign data_wr   = any_wr && bus_addr;
   assign data_acc  = bus_sel && bus_addr && (bus_wr || bus_rd);
   assign port_open = (mode == PORT_OPEN);
   assign dev_range = (index_q >= DEV_BASE_IDX);

   cfgport_keyseq #(
      .KEY_WRITES(KEY_WRITES),
      .UNLOCK_KEY(UNLOCK_KEY),
      .LOCK_KEY  (LOCK_KEY)
   ) u_keyseq (
      .clk   (clk),
      .rst_n (rst_n),
      .idx_wr(idx_wr),
      .any_wr(any_wr),
      .wdata (bus_wdata),
      .mode  (mode)
   );

   cfgport_globals #(
      .CHIP_ID (CHIP_ID),
      .CHIP_REV(CHIP_REV),
      .MAKER_ID(MAKER_ID)
   ) u_globals (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_load  (port_open && idx_wr && bus_wdata != LOCK_KEY),
      .ldn_load  (port_open && data_wr && index_q == IDX_LDSEL),
      .wdata     (bus_wdata),
      .index_q   (index_q),
      .ldn_q     (ldn_q),
      .glob_rdata(glob_rdata)
   );

   assign dev_req   = port_open && data_acc && dev_range;
   assign dev_we    = dev_req && bus_wr;
   assign dev_idx   = index_q;
   assign dev_wdata = bus_wdata;

   cfgport_route #(
      .NUM_LD(NUM_LD)
   ) u_route (
      .req      (dev_req),
      .ldn      (ldn_q),
      .dev_rdata(dev_rdata),
      .dev_sel  (dev_sel),
      .sel_rdata(sel_rdata)
   );

   always_comb begin
      if (!port_open)     bus_rdata = BYTE_ONES;
      else if (!bus_addr) bus_rdata = index_q;
      else if (dev_range) bus_rdata = sel_rdata;
      else                bus_rdata = glob_rdata;
   end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
   parameter int          NUM_LD     = 8,
   parameter logic [7:0]  UNLOCK_KEY = 8'h87,
   parameter logic [7:0]  LOCK_KEY   = 8'hAA,
   parameter logic [15:0] MAKER_ID   = 16'h1934
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              dev_req,
   input logic [NUM_LD-1:0] dev_sel,
   input logic              port_open,
   input logic [7:0]        ldn_q,
   input logic [7:0]        index_q
);
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!port_open && ldn_q == 8'h00 && index_q == 8'h00));

   assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_open) |-> $past(bus_sel && bus_wr && !bus_addr && bus_wdata == UNLOCK_KEY));

   assert_lock_key_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (port_open && bus_sel && bus_wr && !bus_addr && bus_wdata == LOCK_KEY) |=> !port_open);

   assert_locked_reads_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_open && bus_sel && bus_rd) |-> bus_rdata == 8'hFF);

   assert_locked_no_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !port_open |-> !dev_req);

   assert_locked_ldn_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !port_open |=> $stable(ldn_q));

   assert_maker_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (port_open && bus_sel && bus_rd && bus_addr && index_q == 8'h23)
         |-> bus_rdata == MAKER_ID[15:8]);

   assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_sel) && (dev_sel == '0 || dev_req));
endmodule

bind cfg_port cfg_port_chk #(
   .NUM_LD    (NUM_LD),
   .UNLOCK_KEY(UNLOCK_KEY),
   .LOCK_KEY  (LOCK_KEY),
   .MAKER_ID  (MAKER_ID)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .dev_req  (dev_req),
   .dev_sel  (dev_sel),
   .port_open(port_open),
   .ldn_q    (ldn_q),
   .index_q  (index_q)
);

// File: tb/cfg_port_test.sv
module cfg_port_test;
   localparam int          NUM_LD = 8;
   localparam logic [15:0] CHIP   = 16'h0A5C;
   localparam logic [7:0]  REV    = 8'h12;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                bus_sel = 1'b0, bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]          bus_wdata = 8'h00;
   logic [7:0]          bus_rdata;
   logic                dev_req, dev_we;
   logic [NUM_LD-1:0]   dev_sel;
   logic [7:0]          dev_idx, dev_wdata;
   logic [NUM_LD*8-1:0] dev_rdata;

   always #2 clk = ~clk;

   cfg_port #(.NUM_LD(NUM_LD), .CHIP_ID(CHIP), .CHIP_REV(REV), .MAKER_ID(16'h1934)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dev_req(dev_req), .dev_we(dev_we), .dev_sel(dev_sel), .dev_idx(dev_idx),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata));

   // Device model: lane k answers index + 17*k.
   for (genvar k = 0; k < NUM_LD; k++) begin : g_dev
      assign dev_rdata[k*8 +: 8] = dev_idx + 8'(k * 17);
   end

   int total = 0;
   int bad   = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic              s_req, s_we;
   logic [NUM_LD-1:0] s_sel;
   logic [7:0]        s_idx, s_wdata;

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: compares read data against queued expectations.
   always @(negedge clk) begin
      if (bus_sel && bus_rd) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "read with empty scoreboard", {8'h0, bus_rdata}, 16'h0);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata == e, t, {8'h0, bus_rdata}, {8'h0, e});
         end
      end
   end

   task automatic snap();
      s_req = dev_req; s_we = dev_we; s_sel = dev_sel; s_idx = dev_idx; s_wdata = dev_wdata;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_addr = a; bus_wr = 1'b1; bus_rd = 1'b0; bus_wdata = d;
      @(negedge clk); snap();
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
      @(negedge clk); snap();
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 16'h0, 16'h1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 / R4: locked after reset
      rd(1'b1, 8'hFF, "R1 data read after reset");
      check(s_req == 1'b0, "R4 no request while locked", {15'h0, s_req}, 16'h0);
      rd(1'b0, 8'hFF, "R1 index read after reset");

      // R2: foreign index byte between keys restarts
      wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
      rd(1'b1, 8'hFF, "R2 broken by index byte");
      // R2: data-port write between keys restarts
      wr(1'b1, 8'h00); wr(1'b0, 8'h87);
      rd(1'b1, 8'hFF, "R2 broken by data write");
      wr(1'b0, 8'h87);
      rd(1'b0, 8'h00, "R2 open, R1 index reset 0");
      rd(1'b1, 8'h00, "R9 unlisted index 0x00 reads 0");
      check(s_req == 1'b0, "R9 no request below 0x30", {15'h0, s_req}, 16'h0);

      // R5 / R6
      wr(1'b0, 8'h07);
      rd(1'b0, 8'h07, "R5 index readback");
      rd(1'b1, 8'h00, "R1 R6 ldn reset 0");

      // R7 identity
      wr(1'b0, 8'h20); rd(1'b1, CHIP[15:8], "R7 chip id high");
      wr(1'b0, 8'h21); rd(1'b1, CHIP[7:0],  "R7 chip id low");
      wr(1'b0, 8'h22); rd(1'b1, REV,        "R7 revision");
      wr(1'b0, 8'h24); rd(1'b1, 8'h34,      "R7 maker low");
      wr(1'b0, 8'h23); rd(1'b1, 8'h19,      "R7 maker high");
      wr(1'b1, 8'hEE); rd(1'b1, 8'h19,      "R7 write to id ignored");

      // R6 / R8: GPIO device 6
      wr(1'b0, 8'h07); wr(1'b1, 8'h06);
      rd(1'b1, 8'h06, "R6 ldn readback");
      wr(1'b0, 8'h30);
      rd(1'b1, 8'h96, "R8 device 6 read lane");
      check(s_req && !s_we && s_sel == 8'h40, "R8 read request to GPIO device",
            {7'h0, s_req, s_sel}, {7'h0, 1'b1, 8'h40});
      wr(1'b0, 8'h41); wr(1'b1, 8'h5A);
      check(s_req && s_we && s_sel == 8'h40 && s_idx == 8'h41 && s_wdata == 8'h5A,
            "R8 write forward", {s_idx, s_wdata}, 16'h415A);

      // R8 other device
      wr(1'b0, 8'h07); wr(1'b1, 8'h02); wr(1'b0, 8'h30);
      rd(1'b1, 8'h52, "R8 device 2 read lane");
      check(s_sel == 8'h04, "R8 select device 2", {8'h0, s_sel}, 16'h0004);

      // R9 out-of-range device
      wr(1'b0, 8'h07); wr(1'b1, 8'h09); wr(1'b0, 8'h30);
      rd(1'b1, 8'h00, "R9 out of range device read");
      check(s_req && s_sel == 8'h00, "R9 no select out of range", {7'h0, s_req, s_sel}, 16'h0100);

      // R3 / R4: lock, disturb, reopen
      wr(1'b0, 8'h07); wr(1'b1, 8'h06);
      wr(1'b0, 8'hAA);
      rd(1'b1, 8'hFF, "R3 data read after lock");
      rd(1'b0, 8'hFF, "R4 index read while locked");
      wr(1'b1, 8'h03);
      check(s_req == 1'b0, "R4 locked write no request", {15'h0, s_req}, 16'h0);
      wr(1'b0, 8'h20);
      wr(1'b0, 8'h87); wr(1'b0, 8'h87);
      rd(1'b0, 8'h07, "R3 index kept across lock");
      rd(1'b1, 8'h06, "R4 locked data write ignored");

      repeat (2) @(posedge clk);
      check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
      finish_run();
   end
endmodule